// File: doc/BRIEF.md
# DDR SDRAM Command Timing Gate

This block sits on the controller side, between whatever produces DDR SDRAM commands and the logic that drives the memory pins. A requester presents one command at a time: an operation code, a target bank and an auto-precharge flag. The gate raises `cmd_ready` only in a cycle where issuing that exact command breaks none of the inter-command spacing rules. A command is issued on the rising edge where `cmd_valid` and `cmd_ready` are both high. Address generation, refresh scheduling and data capture belong to other blocks.

The interface is valid/ready. `cmd_ready` is a function of the presented command and of the timers, and it is never high while `cmd_valid` is low. While it is low the requester holds the command, or swaps in another one whose legality the gate evaluates afresh in that same cycle. The analog limits are given as picosecond parameters and are rounded up to whole clock cycles. Per-bank timers track the activate-to-column delay, the minimum active time, the precharge time, the row cycle time and write recovery. Global timers track bank-to-bank activate spacing, column spacing, write-to-read turnaround and the mode-register settle time. The write auto-precharge delay is the write-recovery cycle count plus the precharge cycle count, each rounded up on its own. Each timer loads on the issuing edge with the larger of its remaining count and the new requirement.

Top module: `ddr_timing_gate`

## Requirements
- R1: An activate (op 0) is accepted only for a closed bank, no earlier than T_RC cycles after that bank's previous activate and T_RP cycles after its precharge.
- R2: A read (op 1) or write (op 2) is accepted only for an open bank, no earlier than T_RCD cycles after that bank's activate; a column command to a closed bank is held indefinitely.
- R3: A precharge (op 3) to a bank is accepted no earlier than T_RAS cycles after its activate and BURST_CYC+T_WR cycles after a write to it.
- R4: After a write with auto-precharge, the same bank accepts an activate at max(remaining active time, BURST_CYC+T_WR)+T_RP cycles, which is BURST_CYC+T_WR+T_RP cycles once the active time is met.
- R5: After a read with auto-precharge, the same bank accepts an activate at max(remaining active time, BURST_CYC)+T_RP cycles.
- R6: Two activates to any banks are at least T_RRD cycles apart.
- R7: A read is accepted no earlier than BURST_CYC+T_WTR cycles after any write.
- R8: Column commands to any banks are at least T_CCD cycles apart.
- R9: A mode register set (op 5) is accepted only when every bank is closed and past its precharge time; every following command except the no-op codes waits T_MRD cycles.
- R10: Precharge-all (op 4) waits until every bank may be precharged and closes all open banks; a precharge to a closed bank is accepted and does not change that bank's timing.
- R11: After reset all banks are closed and every timer is expired, so a first activate issues in the cycle it is presented.
- R12: cmd_ready is low whenever cmd_valid is low; codes 6 and 7 are no-ops that are always accepted and load no timer.
- R13: Each cycle limit is the picosecond limit divided by CLK_PS and rounded up (65000/7500 gives 9; 20000/7500 gives 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented |
| cmd_op | input | 3 | 0 activate, 1 read, 2 write, 3 precharge, 4 precharge-all, 5 mode register set, 6-7 no-op |
| cmd_bank | input | 2 | Target bank (ignored by precharge-all, mode set and no-op) |
| cmd_ap | input | 1 | Auto-precharge flag for read and write |
| cmd_ready | output | 1 | Presented command may issue on this edge |

## Verification
The embedded properties check on every cycle that activates target closed banks and leave the bank open, and that the next cycle refuses a column command after an activate. They also check that a second activate, a read after a write and any command after a mode set are refused in the cycle following the issue, and that a loaded timer stops reporting expiry. Whether each command issues at exactly its earliest legal cycle, and never earlier, is shown only by the bench's scripted sequences. Those sequences cover row-cycle versus precharge-time races, the two auto-precharge paths, precharge-all across banks with different histories, and commands that must stay blocked.

// File: rtl/ddr_gate_pkg.sv
package ddr_gate_pkg;

  localparam logic [2:0] OP_ACT  = 3'd0;
  localparam logic [2:0] OP_RD   = 3'd1;
  localparam logic [2:0] OP_WR   = 3'd2;
  localparam logic [2:0] OP_PRE  = 3'd3;
  localparam logic [2:0] OP_PREA = 3'd4;
  localparam logic [2:0] OP_MRS  = 3'd5;

  // round a picosecond limit up to whole clock cycles (R13)
  function automatic int ps_to_cyc(input int ps, input int clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_down_ctr.sv
module ddr_down_ctr #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_dec;

  assign cnt_dec = (cnt_q == '0) ? '0 : cnt_q - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= (val > cnt_dec) ? val : cnt_dec;
    else
      cnt_q <= cnt_dec;
  end

  assign zero = (cnt_q == '0);

  // R12: a nonzero load blocks the following cycle
  p_ctr_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (load && val != '0) |=> !zero);

endmodule

// File: rtl/ddr_bank_timer.sv
module ddr_bank_timer
  import ddr_gate_pkg::*;
#(
  parameter int CW        = 5,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 6,
  parameter int T_RC      = 9,
  parameter int T_WR      = 2,
  parameter int BURST_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic do_act,
  input  logic do_rd,
  input  logic do_wr,
  input  logic do_pre,
  input  logic ap,
  output logic open_o,
  output logic col_ok,
  output logic pre_ok,
  output logic act_ok
);

  logic          open_q, open_n;
  logic [CW-1:0] col_q, pre_q, act_q;
  logic [CW-1:0] col_n, pre_n, act_n;

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  always_comb begin
    int unsigned pnow;
    pnow   = int'(pre_q);
    open_n = open_q;
    col_n  = dec(col_q);
    pre_n  = dec(pre_q);
    act_n  = dec(act_q);
    if (do_act) begin
      open_n = 1'b1;
      col_n  = CW'(umax(int'(col_n), T_RCD - 1));
      pre_n  = CW'(umax(int'(pre_n), T_RAS - 1));
      act_n  = CW'(umax(int'(act_n), T_RC - 1));
    end
    if (do_wr) begin
      pre_n = CW'(umax(int'(pre_n), BURST_CYC + T_WR - 1));
      if (ap) begin
        open_n = 1'b0;
        act_n  = CW'(umax(int'(act_n), umax(pnow, BURST_CYC + T_WR) + T_RP - 1));
      end
    end
    if (do_rd && ap) begin
      open_n = 1'b0;
      act_n  = CW'(umax(int'(act_n), umax(pnow, BURST_CYC) + T_RP - 1));
    end
    if (do_pre && open_q) begin
      open_n = 1'b0;
      act_n  = CW'(umax(int'(act_n), T_RP - 1));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      col_q  <= '0;
      pre_q  <= '0;
      act_q  <= '0;
    end else begin
      open_q <= open_n;
      col_q  <= col_n;
      pre_q  <= pre_n;
      act_q  <= act_n;
    end
  end

  assign open_o = open_q;
  assign col_ok = (col_q == '0);
  assign pre_ok = (pre_q == '0);
  assign act_ok = (act_q == '0);

  // R1: activates reach closed banks only and open them
  p_act_closed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    do_act |-> !open_q);
  p_act_opens_r1: assert property (@(posedge clk) disable iff (!rst_n)
    do_act |=> open_o);
  // R4: a write with auto-precharge blocks re-activation next cycle
  p_wrap_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && ap) |=> !act_ok);

  generate
    if (T_RCD > 1) begin : g_rcd_chk
      // R2: no column command in the cycle after an activate
      p_rcd_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
        do_act |=> !col_ok);
    end
  endgenerate

endmodule

// File: rtl/ddr_timing_gate.sv
module ddr_timing_gate
  import ddr_gate_pkg::*;
#(
  parameter int CLK_PS    = 7500,
  parameter int RCD_PS    = 20000,
  parameter int RP_PS     = 20000,
  parameter int RAS_PS    = 45000,
  parameter int RRD_PS    = 15000,
  parameter int WR_PS     = 15000,
  parameter int RC_PS     = 65000,
  parameter int T_WTR     = 1,
  parameter int T_CCD     = 1,
  parameter int T_MRD     = 2,
  parameter int BURST_CYC = 2,
  parameter int NBANK     = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cmd_valid,
  input  logic [2:0]                            cmd_op,
  input  logic [((NBANK > 1) ? $clog2(NBANK) : 1)-1:0] cmd_bank,
  input  logic                                  cmd_ap,
  output logic                                  cmd_ready
);

  localparam int BW    = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int T_RCD = ps_to_cyc(RCD_PS, CLK_PS);
  localparam int T_RP  = ps_to_cyc(RP_PS, CLK_PS);
  localparam int T_RAS = ps_to_cyc(RAS_PS, CLK_PS);
  localparam int T_RRD = ps_to_cyc(RRD_PS, CLK_PS);
  localparam int T_WR  = ps_to_cyc(WR_PS, CLK_PS);
  localparam int T_RC  = ps_to_cyc(RC_PS, CLK_PS);
  localparam int MAXC  = T_RC + T_RAS + T_RP + T_WR + T_RCD + T_RRD
                       + BURST_CYC + T_WTR + T_CCD + T_MRD;
  localparam int CW    = $clog2(MAXC + 1);

  logic             issue;
  logic             is_act, is_rd, is_wr, is_pre, is_prea, is_mrs;
  logic [NBANK-1:0] open_v, col_v, pre_v, act_v;
  logic             rrd_z, ccd_z, wtr_z, mrd_z;
  logic             legal;

  assign is_act  = (cmd_op == OP_ACT);
  assign is_rd   = (cmd_op == OP_RD);
  assign is_wr   = (cmd_op == OP_WR);
  assign is_pre  = (cmd_op == OP_PRE);
  assign is_prea = (cmd_op == OP_PREA);
  assign is_mrs  = (cmd_op == OP_MRS);

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic sel;
      assign sel = (cmd_bank == BW'(b));
      ddr_bank_timer #(
        .CW(CW), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS),
        .T_RC(T_RC), .T_WR(T_WR), .BURST_CYC(BURST_CYC)
      ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .do_act (issue && is_act && sel),
        .do_rd  (issue && is_rd && sel),
        .do_wr  (issue && is_wr && sel),
        .do_pre (issue && ((is_pre && sel) || is_prea)),
        .ap     (cmd_ap),
        .open_o (open_v[b]),
        .col_ok (col_v[b]),
        .pre_ok (pre_v[b]),
        .act_ok (act_v[b])
      );
    end
  endgenerate

  ddr_down_ctr #(.CW(CW)) u_rrd (
    .clk(clk), .rst_n(rst_n), .load(issue && is_act),
    .val(CW'(T_RRD - 1)), .zero(rrd_z));
  ddr_down_ctr #(.CW(CW)) u_ccd (
    .clk(clk), .rst_n(rst_n), .load(issue && (is_rd || is_wr)),
    .val(CW'(T_CCD - 1)), .zero(ccd_z));
  ddr_down_ctr #(.CW(CW)) u_wtr (
    .clk(clk), .rst_n(rst_n), .load(issue && is_wr),
    .val(CW'(BURST_CYC + T_WTR - 1)), .zero(wtr_z));
  ddr_down_ctr #(.CW(CW)) u_mrd (
    .clk(clk), .rst_n(rst_n), .load(issue && is_mrs),
    .val(CW'(T_MRD - 1)), .zero(mrd_z));

  always_comb begin
    unique case (cmd_op)
      OP_ACT:  legal = !open_v[cmd_bank] && act_v[cmd_bank] && rrd_z && mrd_z;
      OP_RD:   legal = open_v[cmd_bank] && col_v[cmd_bank] && ccd_z && wtr_z && mrd_z;
      OP_WR:   legal = open_v[cmd_bank] && col_v[cmd_bank] && ccd_z && mrd_z;
      OP_PRE:  legal = pre_v[cmd_bank] && mrd_z;
      OP_PREA: legal = (&pre_v) && mrd_z;
      OP_MRS:  legal = !(|open_v) && (&act_v) && mrd_z;
      default: legal = 1'b1;
    endcase
  end

  assign cmd_ready = cmd_valid && legal;
  assign issue     = cmd_ready;

  generate
    if (T_MRD > 1) begin : g_mrd_chk
      // R9: after a mode set only no-op codes pass next cycle
      p_mrd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && is_mrs) |=> (!cmd_ready || cmd_op[2:1] == 2'b11));
    end
    if (T_RRD > 1) begin : g_rrd_chk
      // R6: back-to-back activates are refused
      p_rrd_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && is_act) |=> !(cmd_ready && cmd_op == OP_ACT));
    end
    if (BURST_CYC + T_WTR > 1) begin : g_wtr_chk
      // R7: a read never follows a write on the next edge
      p_wtr_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && is_wr) |=> !(cmd_ready && cmd_op == OP_RD));
    end
  endgenerate

endmodule

// File: tb/sim_ddr_timing_gate.sv
module sim_ddr_timing_gate;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd7;
  logic [1:0] cmd_bank = 2'd0;
  logic       cmd_ap = 1'b0;
  logic       cmd_ready;
  logic       probe = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int wait_cnt = 0;
  int q_gap[$];
  string q_tag[$];
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ddr_timing_gate u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .cmd_ready(cmd_ready));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: measures cycles from presentation to issue, compares with queue
  always @(negedge clk) begin
    if (rst_n && cmd_valid && !probe) begin
      if (cmd_ready) begin
        if (q_gap.size() > 0) begin
          int g;
          string t;
          g = q_gap.pop_front();
          t = q_tag.pop_front();
          chk(wait_cnt + 1 == g, t, wait_cnt + 1, g);
        end
        wait_cnt = 0;
      end else begin
        wait_cnt++;
      end
    end
  end

  // driver: push the expected spacing, then present until accepted
  task automatic send(input logic [2:0] op, input logic [1:0] bank, input logic ap,
                      input int gap, input string tag);
    int guard;
    q_gap.push_back(gap);
    q_tag.push_back(tag);
    cmd_op = op; cmd_bank = bank; cmd_ap = ap; cmd_valid = 1'b1;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!cmd_ready && guard < 300);
    if (guard >= 300) chk(1'b0, {tag, " hung"}, guard, gap);
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
  endtask

  task automatic hold(input logic [2:0] op, input logic [1:0] bank, input int n,
                      input string tag);
    probe = 1'b1;
    cmd_op = op; cmd_bank = bank; cmd_ap = 1'b0; cmd_valid = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(cmd_ready == 1'b0, tag, int'(cmd_ready), 0);
    end
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    probe = 1'b0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R12 / R11: idle after reset, ready low without valid
    chk(cmd_ready == 1'b0, "R12 ready without valid", int'(cmd_ready), 0);
    @(posedge clk);
    #1;
    send(3'd0, 2'd0, 1'b0, 1, "R11 first activate immediate");
    send(3'd0, 2'd1, 1'b0, 2, "R6 activate spacing across banks");
    send(3'd1, 2'd1, 1'b0, 3, "R2 activate to read");
    send(3'd2, 2'd1, 1'b0, 1, "R8 column spacing");
    send(3'd1, 2'd0, 1'b0, 3, "R7 write to read turnaround");
    send(3'd3, 2'd1, 1'b0, 1, "R3 precharge after write recovery");
    send(3'd0, 2'd1, 1'b0, 3, "R1 R13 precharge time rounded up");
    send(3'd2, 2'd1, 1'b1, 3, "R2 activate to write");
    send(3'd0, 2'd1, 1'b0, 7, "R4 write auto-precharge delay");
    send(3'd1, 2'd1, 1'b1, 3, "R2 activate to read again");
    send(3'd0, 2'd1, 1'b0, 6, "R5 read auto-precharge delay");
    send(3'd4, 2'd0, 1'b0, 6, "R10 precharge-all waits active time");
    send(3'd5, 2'd0, 1'b0, 3, "R9 mode set waits precharge time");
    send(3'd3, 2'd2, 1'b0, 2, "R9 settle after mode set");
    send(3'd0, 2'd2, 1'b0, 1, "R10 precharge to closed bank no effect");
    send(3'd6, 2'd0, 1'b0, 1, "R12 no-op accepted");
    hold(3'd1, 2'd3, 5, "R2 read to closed bank held");
    hold(3'd0, 2'd2, 5, "R1 activate to open bank held");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    if (q_gap.size() != 0) chk(1'b0, "R12 commands left unissued", q_gap.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule